// File: doc/BRIEF.md
# Vectored Interrupt Channel Manager

This block collects a set of raw interrupt request lines and gives each of its channels a programmable source: every channel selects one request line through a byte-wide request number. Each channel has an enable mask bit and a steering bit that sends it either to the fast interrupt output or to the normal interrupt output. For each output the block picks the pending channel with the lowest number, reports it as channel-plus-one in an index (zero meaning nothing pending), and presents the handler address for that channel from a small vector table.

Software configures the block through a single-cycle register write port and a combinational read port. The vector table is written through the same port and each entry carries an even parity bit. A parity mismatch on the entry being presented raises a sticky error flag and captures the byte address of the failing entry, from which the channel can be recovered as (address >> 2) - 1. The fast path has priority when both outputs have a pending channel: the vector output then follows the fast index.

Top module: `irq_chan_mgr`

## Requirements
- R1: The enable mask is changed only through the set words (0x04 + bank) and clear words (0x08 + bank): a 1 in the written data sets or clears that channel's bit, a 0 leaves it unchanged, and reading either word returns the current mask of that bank.
- R2: Steering words at 0x00 + bank hold one bit per channel, channel c at bit (c mod 32) of bank (c / 32); a 1 steers the channel to the fast output, a 0 to the normal output.
- R3: Channel-control word 0x20 + i holds the request numbers of channels 4i..4i+3, channel 4i+k in bits [31-8k -: 8]; after reset channel n maps to request n, and a request number at or above NUM_REQ never makes its channel pending.
- R4: Channels 0 and 1 are always enabled and always steered to the fast output; writes to their mask and steering bits are ignored and those bits read back as 1.
- R5: A channel is pending when its mapped request line is high and its mask bit is set; fiq_o and irq_o are the OR of pending channels on each path and change on the first clock edge after the request changes.
- R6: On each output the pending channel with the lowest number wins.
- R7: The fast and normal indices (ports, and read words 0x0C and 0x0D) show the winning channel number plus one, and 0 when nothing on that path is pending.
- R8: Vector-table entry e is written and read at word 0x80 + e; vec_o presents the entry selected by the fast index when it is nonzero and otherwise the entry selected by the normal index, so entry 0 appears when nothing is pending.
- R9: Every table write stores even parity, inverted when bit 0 of the control word 0x10 is set; while either index is nonzero, a mismatch on the presented entry sets the error flag (bit 0 of word 0x0E, port par_err_o) and captures the byte address 4*e in word 0x0F; the first captured address is held while the flag is set.
- R10: Writing 1 to bit 0 of word 0x0E clears the error flag; writing 0 leaves it set.
- R11: After reset all configurable mask and steering bits are 0, both indices and both outputs are 0, the vector table holds zero with good parity and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_REQ | Raw interrupt request lines, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_idx_o | output | IDX_W | Winning fast channel plus one, 0 when none |
| irq_idx_o | output | IDX_W | Winning normal channel plus one, 0 when none |
| vec_o | output | VEC_W | Handler address of the presented channel |
| par_err_o | output | 1 | Sticky vector-table parity error flag |

## Verification
The hardest state to reach from the ports is a parity error on the vector table, since a correctly working write path always stores good parity. The stimulus sets the control bit that stores inverted parity, writes one entry, clears the bit and then raises a request on the matching channel so the corrupted entry is presented; the captured address, the flag's resistance to a zero write and its recovery after the entry is rewritten are then checked. Channels in the second mask bank and a remapped request number out of range are the other cases reached only by deliberate reprogramming.

// File: rtl/icm_pkg.sv
package icm_pkg;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned REQ_NUM_W = 8;

  localparam logic [REG_AW-1:0] A_SEL   = 8'h00;
  localparam logic [REG_AW-1:0] A_MSET  = 8'h04;
  localparam logic [REG_AW-1:0] A_MCLR  = 8'h08;
  localparam logic [REG_AW-1:0] A_FIDX  = 8'h0C;
  localparam logic [REG_AW-1:0] A_IIDX  = 8'h0D;
  localparam logic [REG_AW-1:0] A_ERR   = 8'h0E;
  localparam logic [REG_AW-1:0] A_EADDR = 8'h0F;
  localparam logic [REG_AW-1:0] A_CTRL  = 8'h10;
  localparam logic [REG_AW-1:0] A_CHCTL = 8'h20;
  localparam logic [REG_AW-1:0] A_VTAB  = 8'h80;

  function automatic logic [REG_AW-1:0] icm_off(logic [REG_AW-1:0] base, int unsigned i);
    return base + REG_AW'(i);
  endfunction

endpackage

// File: rtl/icm_cfg.sv
module icm_cfg
  import icm_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_i,
  input  logic [REG_AW-1:0]               addr_i,
  input  logic [REG_DW-1:0]               wdata_i,
  output logic [NUM_CH-1:0]               sel_eff_o,
  output logic [NUM_CH-1:0]               mask_eff_o,
  output logic [NUM_CH-1:0][REQ_NUM_W-1:0] map_o,
  output logic                            inj_o,
  output logic                            hit_o,
  output logic [REG_DW-1:0]               rdata_o
);

  localparam int unsigned NB = NUM_CH / 32;
  localparam int unsigned NW = NUM_CH / 4;
  localparam logic [NUM_CH-1:0] FIXED = {{(NUM_CH-2){1'b0}}, 2'b11};

  logic [NUM_CH-1:0] sel_q, sel_d, mask_q, mask_d;
  logic [NUM_CH-1:0][REQ_NUM_W-1:0] map_q, map_d;
  logic inj_q, inj_d;
  logic sel_en, mask_en, map_en, inj_en;

  // next state
  always_comb begin
    sel_d   = sel_q;
    mask_d  = mask_q;
    map_d   = map_q;
    inj_d   = inj_q;
    sel_en  = 1'b0;
    mask_en = 1'b0;
    map_en  = 1'b0;
    inj_en  = 1'b0;
    if (wr_i) begin
      for (int b = 0; b < NB; b++) begin
        if (addr_i == icm_off(A_SEL, b)) begin
          sel_d[b*32 +: 32] = wdata_i;
          sel_en = 1'b1;
        end
        if (addr_i == icm_off(A_MSET, b)) begin
          mask_d[b*32 +: 32] = mask_q[b*32 +: 32] | wdata_i;
          mask_en = 1'b1;
        end
        if (addr_i == icm_off(A_MCLR, b)) begin
          mask_d[b*32 +: 32] = mask_q[b*32 +: 32] & ~wdata_i;
          mask_en = 1'b1;
        end
      end
      for (int w = 0; w < NW; w++) begin
        if (addr_i == icm_off(A_CHCTL, w)) begin
          for (int k = 0; k < 4; k++) begin
            map_d[4*w+k] = wdata_i[8*(3-k) +: 8];
          end
          map_en = 1'b1;
        end
      end
      if (addr_i == A_CTRL) begin
        inj_d  = wdata_i[0];
        inj_en = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mask_q <= '0;
      inj_q  <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        map_q[c] <= REQ_NUM_W'(c);
      end
    end else begin
      if (sel_en)  sel_q  <= sel_d;
      if (mask_en) mask_q <= mask_d;
      if (map_en)  map_q  <= map_d;
      if (inj_en)  inj_q  <= inj_d;
    end
  end

  assign sel_eff_o  = sel_q | FIXED;
  assign mask_eff_o = mask_q | FIXED;
  assign map_o      = map_q;
  assign inj_o      = inj_q;

  // read mux
  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (addr_i == icm_off(A_SEL, b)) begin
        rdata_o = sel_eff_o[b*32 +: 32];
        hit_o   = 1'b1;
      end
      if (addr_i == icm_off(A_MSET, b) || addr_i == icm_off(A_MCLR, b)) begin
        rdata_o = mask_eff_o[b*32 +: 32];
        hit_o   = 1'b1;
      end
    end
    for (int w = 0; w < NW; w++) begin
      if (addr_i == icm_off(A_CHCTL, w)) begin
        for (int k = 0; k < 4; k++) begin
          rdata_o[8*(3-k) +: 8] = map_q[4*w+k];
        end
        hit_o = 1'b1;
      end
    end
    if (addr_i == A_CTRL) begin
      rdata_o = {{(REG_DW-1){1'b0}}, inj_q};
      hit_o   = 1'b1;
    end
  end

endmodule

// File: rtl/icm_prio_enc.sv
module icm_prio_enc #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i + 1);
    end
  end

  assign any_o = |pend_i;

endmodule

// File: rtl/icm_vec_table.sv
module icm_vec_table
  import icm_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned VEC_W  = 32,
  parameter int unsigned IW     = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              inj_i,
  input  logic [IW-1:0]     fidx_i,
  input  logic [IW-1:0]     iidx_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              err_o,
  output logic              hit_o,
  output logic [REG_DW-1:0] rdata_o
);

  localparam int unsigned NE   = NUM_CH + 1;
  localparam int unsigned EA_W = IW + 2;

  logic [VEC_W-1:0] data_q [NE];
  logic [NE-1:0]    par_q;
  logic [NE-1:0]    we;
  logic [IW-1:0]    sel_idx;
  logic             fail;
  logic             err_q, err_d, err_en;
  logic [EA_W-1:0]  eaddr_q, eaddr_d;

  always_comb begin
    we = '0;
    for (int e = 0; e < NE; e++) begin
      if (wr_i && addr_i == icm_off(A_VTAB, e)) we[e] = 1'b1;
    end
  end

  generate
    for (genvar e = 0; e < NE; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[e] <= '0;
          par_q[e]  <= 1'b0;
        end else if (we[e]) begin
          data_q[e] <= wdata_i[VEC_W-1:0];
          par_q[e]  <= (^wdata_i[VEC_W-1:0]) ^ inj_i;
        end
      end
    end
  endgenerate

  assign sel_idx = (fidx_i != '0) ? fidx_i : iidx_i;
  assign vec_o   = data_q[sel_idx];
  assign fail    = (sel_idx != '0) && ((^data_q[sel_idx]) != par_q[sel_idx]);

  // error flag next state: clear wins, first error holds its address
  always_comb begin
    err_d   = err_q;
    eaddr_d = eaddr_q;
    err_en  = 1'b0;
    if (wr_i && addr_i == A_ERR && wdata_i[0]) begin
      err_d  = 1'b0;
      err_en = 1'b1;
    end else if (fail && !err_q) begin
      err_d   = 1'b1;
      eaddr_d = {sel_idx, 2'b00};
      err_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      eaddr_q <= '0;
    end else if (err_en) begin
      err_q   <= err_d;
      eaddr_q <= eaddr_d;
    end
  end

  assign err_o = err_q;

  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b0;
    if (addr_i == A_ERR) begin
      rdata_o = {{(REG_DW-1){1'b0}}, err_q};
      hit_o   = 1'b1;
    end
    if (addr_i == A_EADDR) begin
      rdata_o = REG_DW'(eaddr_q);
      hit_o   = 1'b1;
    end
    for (int e = 0; e < NE; e++) begin
      if (addr_i == icm_off(A_VTAB, e)) begin
        rdata_o = REG_DW'(data_q[e]);
        hit_o   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_chan_mgr.sv
module irq_chan_mgr
  import icm_pkg::*;
#(
  parameter int unsigned NUM_CH  = 64,
  parameter int unsigned NUM_REQ = 64,
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_CH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               reg_wr_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               fiq_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   fiq_idx_o,
  output logic [IDX_W-1:0]   irq_idx_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               par_err_o
);

  localparam int unsigned REQ_SPACE = 1 << REQ_NUM_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_CH-1:0]                sel_eff, mask_eff, pend, fpend, ipend;
  logic [NUM_CH-1:0][REQ_NUM_W-1:0] map;
  logic                             inj;
  logic                             cfg_hit, vt_hit;
  logic [REG_DW-1:0]                cfg_rdata, vt_rdata;
  logic [REQ_SPACE-1:0]             req_ext;
  logic [IDX_W-1:0]                 fidx_d, iidx_d, fidx_q, iidx_q;
  logic                             fany, iany, fiq_q, irq_q;

  icm_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .sel_eff_o (sel_eff),
    .mask_eff_o(mask_eff),
    .map_o     (map),
    .inj_o     (inj),
    .hit_o     (cfg_hit),
    .rdata_o   (cfg_rdata)
  );

  assign req_ext = REQ_SPACE'(req_i);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      pend[c] = mask_eff[c] && req_ext[map[c]];
    end
  end

  assign fpend = pend & sel_eff;
  assign ipend = pend & ~sel_eff;

  icm_prio_enc #(.N(NUM_CH), .IW(IDX_W)) u_fenc (
    .pend_i(fpend), .idx_o(fidx_d), .any_o(fany)
  );
  icm_prio_enc #(.N(NUM_CH), .IW(IDX_W)) u_ienc (
    .pend_i(ipend), .idx_o(iidx_d), .any_o(iany)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fidx_q <= '0;
      iidx_q <= '0;
      fiq_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      fidx_q <= fidx_d;
      iidx_q <= iidx_d;
      fiq_q  <= fany;
      irq_q  <= iany;
    end
  end

  icm_vec_table #(.NUM_CH(NUM_CH), .VEC_W(VEC_W), .IW(IDX_W)) u_vtab (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .inj_i  (inj),
    .fidx_i (fidx_q),
    .iidx_i (iidx_q),
    .vec_o  (vec_o),
    .err_o  (par_err_o),
    .hit_o  (vt_hit),
    .rdata_o(vt_rdata)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (cfg_hit)                     reg_rdata_o = cfg_rdata;
    else if (vt_hit)                 reg_rdata_o = vt_rdata;
    else if (reg_addr_i == A_FIDX)   reg_rdata_o = REG_DW'(fidx_q);
    else if (reg_addr_i == A_IIDX)   reg_rdata_o = REG_DW'(iidx_q);
  end

  assign fiq_o     = fiq_q;
  assign irq_o     = irq_q;
  assign fiq_idx_o = fidx_q;
  assign irq_idx_o = iidx_q;

endmodule

// File: rtl/icm_checker.sv
module icm_checker
  import icm_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned IDX_W  = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [7:0]        addr,
  input logic              wbit0,
  input logic              wbit2,
  input logic [NUM_CH-1:0] fpend,
  input logic [NUM_CH-1:0] mask_eff,
  input logic [NUM_CH-1:0] sel_eff,
  input logic              fiq,
  input logic              irq,
  input logic [IDX_W-1:0]  fidx,
  input logic [IDX_W-1:0]  iidx,
  input logic              err
);

  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  logic [NUM_CH-1:0] lo_f;
  assign lo_f = fpend & (~fpend + ONE);

  assert_fixed_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_eff[1:0] == 2'b11) && (sel_eff[1:0] == 2'b11));

  assert_fiq_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq == (fidx != '0));

  assert_irq_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iidx != '0));

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fidx != '0) |-> ($past(lo_f) == (ONE << (fidx - 1'b1))));

  assert_mask_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_MSET && wbit2) |=> mask_eff[2]);

  assert_mask_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_MCLR && wbit2) |=> !mask_eff[2]);

  assert_paths_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fidx != '0 && iidx != '0) |-> (fidx != iidx));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(wr && addr == A_ERR && wbit0)) |=> err);

endmodule

bind irq_chan_mgr icm_checker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .wr      (reg_wr_i),
  .addr    (reg_addr_i),
  .wbit0   (reg_wdata_i[0]),
  .wbit2   (reg_wdata_i[2]),
  .fpend   (fpend),
  .mask_eff(mask_eff),
  .sel_eff (sel_eff),
  .fiq     (fiq_o),
  .irq     (irq_o),
  .fidx    (fiq_idx_o),
  .iidx    (irq_idx_o),
  .err     (par_err_o)
);

// File: tb/test_irq_chan_mgr.sv
module test_irq_chan_mgr;

  localparam int NUM_CH  = 64;
  localparam int NUM_REQ = 64;
  localparam int IDX_W   = 7;
  localparam logic [31:0] VB = 32'hC0DE_0000;

  // {mask bank0, steer bank0, requests, exp fast idx, exp normal idx}
  localparam int NV = 8;
  localparam logic [143:0] VECS [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 64'h0000_0000_0000_00F0, 8'd0,  8'd0},
    {32'h0000_0030, 32'h0000_0000, 64'h0000_0000_0000_00F0, 8'd0,  8'd5},
    {32'h0000_0030, 32'h0000_0010, 64'h0000_0000_0000_00F0, 8'd5,  8'd6},
    {32'h0000_0F00, 32'h0000_0000, 64'h0000_0000_0000_0C00, 8'd0,  8'd11},
    {32'hFFFF_FFFC, 32'hAAAA_AAA8, 64'h0000_0000_8000_0000, 8'd32, 8'd0},
    {32'hFFFF_FFFC, 32'hAAAA_AAA8, 64'h0000_0000_0000_0003, 8'd1,  8'd0},
    {32'h0000_0004, 32'h0000_0000, 64'h0000_0000_0000_0005, 8'd1,  8'd3},
    {32'hFFFF_FFFC, 32'h0000_0000, 64'h0000_0000_FFFF_0000, 8'd0,  8'd17}
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_REQ-1:0] req;
  logic               wr;
  logic [7:0]         addr;
  logic [31:0]        wdata;
  logic [31:0]        rdata;
  logic               fiq, irq, perr;
  logic [IDX_W-1:0]   fidx, iidx;
  logic [31:0]        vec;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_chan_mgr #(.NUM_CH(NUM_CH), .NUM_REQ(NUM_REQ)) i_irq_chan_mgr (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .reg_wr_i   (wr),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .fiq_o      (fiq),
    .irq_o      (irq),
    .fiq_idx_o  (fidx),
    .irq_idx_o  (iidx),
    .vec_o      (vec),
    .par_err_o  (perr)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m, s;
    logic [7:0]  ef, ei;
    rst_n = 1'b0; req = '0; wr = 1'b0; addr = '0; wdata = '0;
    settle(5);
    rst_n = 1'b1;
    settle(4);

    // R11 reset state
    check("R11 fiq_o", 64'(fiq), 64'd0);
    check("R11 irq_o", 64'(irq), 64'd0);
    rreg(8'h0C, d); check("R11 fast index word", 64'(d), 64'd0);
    rreg(8'h04, d); check("R11 R4 mask bank0", 64'(d), 64'h3);
    rreg(8'h00, d); check("R11 R4 steer bank0", 64'(d), 64'h3);
    rreg(8'h20, d); check("R11 R3 map word0", 64'(d), 64'h0001_0203);
    rreg(8'h21, d); check("R11 R3 map word1", 64'(d), 64'h0405_0607);
    rreg(8'h0E, d); check("R11 error flag", 64'(d), 64'd0);
    rreg(8'h85, d); check("R11 table entry 5", 64'(d), 64'd0);

    // program vector table
    for (int e = 0; e <= NUM_CH; e++) wreg(8'h80 + 8'(e), VB + 32'(e));
    rreg(8'hC0, d); check("R8 table entry 64 readback", 64'(d), 64'(VB + 32'd64));

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      m = VECS[v][143:112]; s = VECS[v][111:80];
      ef = VECS[v][15:8];   ei = VECS[v][7:0];
      wreg(8'h08, 32'hFFFF_FFFF);
      wreg(8'h04, m);
      wreg(8'h00, s);
      @(negedge clk); req = VECS[v][79:16];
      settle(2);
      check($sformatf("R6 R7 R2 vec%0d fast idx", v), 64'(fidx), 64'(ef));
      check($sformatf("R6 R7 R2 vec%0d normal idx", v), 64'(iidx), 64'(ei));
      check($sformatf("R5 vec%0d fiq_o", v), 64'(fiq), 64'(ef != 0));
      check($sformatf("R5 vec%0d irq_o", v), 64'(irq), 64'(ei != 0));
      check($sformatf("R8 vec%0d vector", v), 64'(vec),
            64'((ef != 0) ? VB + 32'(ef) : VB + 32'(ei)));
      rreg(8'h0D, d); check($sformatf("R7 vec%0d normal idx word", v), 64'(d), 64'(ei));
    end

    // R5 latency: one edge from request to output
    @(negedge clk); req = '0;
    wreg(8'h08, 32'hFFFF_FFFF);
    wreg(8'h04, 32'h0000_0040);
    wreg(8'h00, 32'h0);
    settle(2);
    @(negedge clk); req[6] = 1'b1;
    #1 check("R5 irq_o before edge", 64'(irq), 64'd0);
    @(negedge clk);
    check("R5 irq_o after one edge", 64'(irq), 64'd1);
    check("R7 normal idx after one edge", 64'(iidx), 64'd7);
    req = '0;

    // R1 write-one semantics
    wreg(8'h08, 32'hFFFF_FFFF);
    wreg(8'h04, 32'h0000_0100);
    rreg(8'h04, d); check("R1 set bit8", 64'(d), 64'h103);
    wreg(8'h04, 32'h0);
    rreg(8'h04, d); check("R1 set with zero no effect", 64'(d), 64'h103);
    wreg(8'h08, 32'h0);
    rreg(8'h08, d); check("R1 clear with zero no effect", 64'(d), 64'h103);
    wreg(8'h08, 32'h0000_0100);
    rreg(8'h08, d); check("R1 clear bit8", 64'(d), 64'h3);

    // R4 fixed channels
    wreg(8'h08, 32'h0000_0003);
    wreg(8'h00, 32'h0);
    rreg(8'h04, d); check("R4 mask bits stay set", 64'(d), 64'h3);
    rreg(8'h00, d); check("R4 steer bits stay set", 64'(d), 64'h3);
    @(negedge clk); req = 64'h2;
    settle(2);
    check("R4 channel 1 on fast path", 64'(fidx), 64'd2);
    check("R4 channel 1 not on normal path", 64'(iidx), 64'd0);
    req = '0;

    // R3 remap
    wreg(8'h20, 32'h0001_2803);
    rreg(8'h20, d); check("R3 map word readback", 64'(d), 64'h0001_2803);
    wreg(8'h04, 32'h0000_0004);
    @(negedge clk); req = 64'h4;
    settle(2);
    check("R3 old request ignored", 64'(iidx), 64'd0);
    @(negedge clk); req = 64'h1 << 40;
    settle(2);
    check("R3 new request routes ch2", 64'(iidx), 64'd3);
    wreg(8'h20, 32'h0001_C803);
    @(negedge clk); req = ~64'h3;
    settle(2);
    check("R3 out-of-range request never pends", 64'(iidx), 64'd0);
    check("R3 out-of-range fast idle", 64'(fidx), 64'd0);
    wreg(8'h20, 32'h0001_0203);
    wreg(8'h08, 32'hFFFF_FFFF);
    @(negedge clk); req = '0;

    // R2 second bank
    wreg(8'h05, 32'h0000_0100);
    wreg(8'h01, 32'h0000_0100);
    @(negedge clk); req = 64'h1 << 40;
    settle(2);
    check("R2 bank1 fast idx", 64'(fidx), 64'd41);
    check("R8 bank1 vector", 64'(vec), 64'(VB + 32'd41));
    wreg(8'h01, 32'h0);
    settle(2);
    check("R2 bank1 normal idx", 64'(iidx), 64'd41);
    check("R2 bank1 fast idle", 64'(fidx), 64'd0);
    wreg(8'h09, 32'hFFFF_FFFF);
    @(negedge clk); req = '0;

    // R9 / R10 parity
    wreg(8'h10, 32'h1);
    wreg(8'h86, 32'h0000_1234);
    wreg(8'h10, 32'h0);
    settle(2);
    check("R9 no error while idle", 64'(perr), 64'd0);
    wreg(8'h04, 32'h0000_0020);
    @(negedge clk); req = 64'h20;
    settle(3);
    check("R9 error flag set", 64'(perr), 64'd1);
    rreg(8'h0F, d); check("R9 captured address", 64'(d), 64'd24);
    check("R9 recovered channel", 64'((d >> 2) - 1), 64'd5);
    wreg(8'h0E, 32'h0);
    settle(1);
    check("R10 zero write keeps flag", 64'(perr), 64'd1);
    wreg(8'h86, VB + 32'd6);
    wreg(8'h0E, 32'h1);
    settle(2);
    check("R10 flag cleared", 64'(perr), 64'd0);
    rreg(8'h0E, d); check("R10 flag word cleared", 64'(d), 64'd0);
    check("R8 repaired vector", 64'(vec), 64'(VB + 32'd6));

    // R8 nothing pending presents entry 0
    @(negedge clk); req = '0;
    settle(2);
    check("R8 entry 0 when idle", 64'(vec), 64'(VB));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule